// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block produces the system reset for a processor subsystem from two causes: a supply-low flag delivered synchronously by an external voltage comparator, and an active-low manual reset request that arrives asynchronously from a push button or a logic line. Short dips of the supply flag are filtered out. Narrow glitches on the manual input are removed by a synchronizer and a debouncer. Either accepted cause yields a reset output whose active level is chosen by a parameter.

A supply-low condition keeps reset asserted for as long as it lasts. A fixed recovery time-out then follows once the supply is back. A manual request is taken on the falling edge of the debounced input. It produces exactly one pulse of the same fixed length and cannot be retriggered. A lock-out window follows the pulse, and during it manual requests are not accepted. After the window the input has to be seen high and fall again before another pulse can start. A supply event overrides any manual activity and cancels a pending lock-out. Every duration is a parameter in clock cycles. At a 50 MHz clock the defaults give about 1.4 s of time-out, 85 µs of lock-out, 20 µs of supply glitch immunity and 10 µs of debounce.

Top module: `sup_reset_gen`

## Requirements
- R1: While `rst_n` is low the reset output is asserted. With `supply_low` low, it stays asserted for exactly TIMEOUT_CYC+1 rising clock edges after `rst_n` rises, and it is released after that edge.
- R2: A run of fewer than GLITCH_CYC consecutive high samples of `supply_low` has no effect on the output. A run of GLITCH_CYC samples asserts reset after edge GLITCH_CYC+1, counting the first edge that samples it high as edge 1.
- R3: Reset stays asserted while the supply-low condition lasts. Counting the first edge that samples `supply_low` low as edge 1, it is still asserted after edge TIMEOUT_CYC+1 and released after edge TIMEOUT_CYC+2.
- R4: `man_rst_n` passes through SYNC_STAGES flops that reset high. A low level shorter than DEBOUNCE_CYC samples after synchronization is ignored.
- R5: A falling edge on `man_rst_n`, sampled low from edge 1 on, asserts reset after edge SYNC_STAGES+DEBOUNCE_CYC+1. The pulse lasts exactly TIMEOUT_CYC cycles, however long the input is then held low.
- R6: Falling edges on the manual input during a manual pulse neither extend nor restart it.
- R7: For LOCKOUT_CYC cycles after a manual pulse ends, manual falling edges are ignored. A low level held through the lock-out does not retrigger. Once the input is seen high and falls again, a new pulse starts.
- R8: An accepted supply-low condition during a manual pulse or its lock-out takes over. Reset is held until the supply has recovered plus one time-out (timed as in R3). The lock-out is cancelled, so a manual falling edge right after that time-out is accepted.
- R9: With ACTIVE_HIGH=0 the output is 0 while reset is active and 1 otherwise. With ACTIVE_HIGH=1 it is 1 while reset is active and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| supply_low | input | 1 | Synchronous flag from the comparator, high while the supply is under threshold |
| man_rst_n | input | 1 | Asynchronous active-low manual reset request, idle high |
| sys_rst | output | 1 | System reset, active level set by ACTIVE_HIGH |

## Verification
The supply path and the manual path can act in the same cycle. For example, an accepted supply-low flag can arrive while a manual pulse is counting, or during its lock-out, or just as a debounced manual fall reaches the sequencer. The bench forces these overlaps in two ways. Directed steps place a supply dip inside a pulse and inside a lock-out. A seeded random phase interleaves dips of every length with bouncing manual input. A bench reference model that gives the supply path priority then judges the output on every cycle. Checks on the recovery timing and on the next accepted manual edge confirm that the lock-out was cancelled.

// File: rtl/sup_reset_pkg.sv
package sup_reset_pkg;

   typedef enum logic [2:0] {
      SR_HOLD     = 3'd0,
      SR_RECOVER  = 3'd1,
      SR_IDLE     = 3'd2,
      SR_MANUAL   = 3'd3,
      SR_LOCKOUT  = 3'd4
   } sr_state_e;

   // States in which the system reset is driven active
   function automatic logic sr_drives_reset(sr_state_e s);
      return (s == SR_HOLD) || (s == SR_RECOVER) || (s == SR_MANUAL);
   endfunction

endpackage

// File: rtl/sup_in_sync.sv
// Multi-flop synchronizer for an asynchronous, idle-high input.
module sup_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   logic [STAGES-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '1;
      else        stg <= {stg[STAGES-2:0], d_async};
   end

   assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/sup_debounce.sv
// Accepts a new level after CYC consecutive differing samples and
// emits a single-cycle strobe when the accepted level goes low.
module sup_debounce #(
   parameter int CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level_in,
   output logic fell_o
);
   localparam int CW = $clog2(CYC + 1);
   localparam logic [CW-1:0] LAST = CW'(CYC - 1);

   logic          level_q;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= 1'b1;
         cnt     <= '0;
         fell_o  <= 1'b0;
      end else begin
         fell_o <= 1'b0;
         if (level_in == level_q) begin
            cnt <= '0;
         end else if (cnt == LAST) begin
            level_q <= level_in;
            cnt     <= '0;
            fell_o  <= ~level_in;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/sup_dip_filter.sv
// Accepts the supply-low flag only after CYC consecutive high samples.
module sup_dip_filter #(
   parameter int CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_low,
   output logic flt_low
);
   localparam int CW = $clog2(CYC + 1);
   localparam logic [CW-1:0] LAST = CW'(CYC - 1);

   logic [CW-1:0] run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run     <= '0;
         flt_low <= 1'b0;
      end else if (!raw_low) begin
         run     <= '0;
         flt_low <= 1'b0;
      end else if (run == LAST) begin
         flt_low <= 1'b1;
      end else begin
         run <= run + 1'b1;
      end
   end
endmodule

// File: rtl/sup_seq.sv
// Reset sequencer: supply hold, recovery time-out, manual pulse, lock-out.
module sup_seq
   import sup_reset_pkg::*;
#(
   parameter int TIMEOUT_CYC = 64,
   parameter int LOCKOUT_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sup_flt,
   input  logic man_fell,
   output logic rst_act,
   output logic lock_act
);
   localparam int MAXC = (TIMEOUT_CYC > LOCKOUT_CYC) ? TIMEOUT_CYC : LOCKOUT_CYC;
   localparam int CW   = $clog2(MAXC + 1);
   localparam logic [CW-1:0] T_LAST = CW'(TIMEOUT_CYC - 1);
   localparam logic [CW-1:0] L_LAST = CW'(LOCKOUT_CYC - 1);

   sr_state_e     st, st_nx;
   logic [CW-1:0] cnt, cnt_nx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= SR_HOLD;
         cnt <= '0;
      end else begin
         st  <= st_nx;
         cnt <= cnt_nx;
      end
   end

   always_comb begin
      st_nx  = st;
      cnt_nx = cnt + 1'b1;
      if (sup_flt) begin
         // supply monitoring overrides every other activity
         st_nx  = SR_HOLD;
         cnt_nx = '0;
      end else begin
         unique case (st)
            SR_HOLD: begin
               st_nx  = SR_RECOVER;
               cnt_nx = '0;
            end
            SR_RECOVER: begin
               if (cnt == T_LAST) begin
                  st_nx  = SR_IDLE;
                  cnt_nx = '0;
               end
            end
            SR_IDLE: begin
               cnt_nx = '0;
               if (man_fell) st_nx = SR_MANUAL;
            end
            SR_MANUAL: begin
               if (cnt == T_LAST) begin
                  st_nx  = SR_LOCKOUT;
                  cnt_nx = '0;
               end
            end
            SR_LOCKOUT: begin
               if (cnt == L_LAST) begin
                  st_nx  = SR_IDLE;
                  cnt_nx = '0;
               end
            end
            default: begin
               st_nx  = SR_HOLD;
               cnt_nx = '0;
            end
         endcase
      end
   end

   assign rst_act  = sr_drives_reset(st);
   assign lock_act = (st == SR_LOCKOUT);
endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen #(
   parameter int TIMEOUT_CYC  = 70_000_000,
   parameter int LOCKOUT_CYC  = 4_250,
   parameter int GLITCH_CYC   = 1_000,
   parameter int DEBOUNCE_CYC = 500,
   parameter int SYNC_STAGES  = 2,
   parameter bit ACTIVE_HIGH  = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_low,
   input  logic man_rst_n,
   output logic sys_rst
);
   // elaboration-time parameter checks
   if (TIMEOUT_CYC < 1) begin : g_bad_timeout
      $error("sup_reset_gen: TIMEOUT_CYC must be at least 1");
   end
   if (LOCKOUT_CYC < 1) begin : g_bad_lockout
      $error("sup_reset_gen: LOCKOUT_CYC must be at least 1");
   end
   if (GLITCH_CYC < 1) begin : g_bad_glitch
      $error("sup_reset_gen: GLITCH_CYC must be at least 1");
   end
   if (DEBOUNCE_CYC < 1) begin : g_bad_debounce
      $error("sup_reset_gen: DEBOUNCE_CYC must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("sup_reset_gen: SYNC_STAGES must be at least 2");
   end

   logic man_sync;
   logic man_fell;
   logic sup_flt;
   logic rst_act;
   logic lock_act;

   sup_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (man_rst_n),
      .q_sync  (man_sync)
   );

   sup_debounce #(.CYC(DEBOUNCE_CYC)) u_debounce (
      .clk      (clk),
      .rst_n    (rst_n),
      .level_in (man_sync),
      .fell_o   (man_fell)
   );

   sup_dip_filter #(.CYC(GLITCH_CYC)) u_dip (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_low (supply_low),
      .flt_low (sup_flt)
   );

   sup_seq #(.TIMEOUT_CYC(TIMEOUT_CYC), .LOCKOUT_CYC(LOCKOUT_CYC)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .sup_flt  (sup_flt),
      .man_fell (man_fell),
      .rst_act  (rst_act),
      .lock_act (lock_act)
   );

   if (ACTIVE_HIGH) begin : g_pol_high
      assign sys_rst = rst_act;
   end else begin : g_pol_low
      assign sys_rst = ~rst_act;
   end
endmodule

// File: rtl/sup_reset_chk.sv
module sup_reset_chk #(
   parameter int TIMEOUT_CYC  = 64,
   parameter int LOCKOUT_CYC  = 16,
   parameter int GLITCH_CYC   = 8,
   parameter int DEBOUNCE_CYC = 4
) (
   input logic clk,
   input logic rst_n,
   input logic supply_low,
   input logic man_sync,
   input logic man_fell,
   input logic sup_flt,
   input logic rst_act,
   input logic lock_act
);
   int unsigned low_run, sync_low_run, act_len, lock_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run      <= 0;
         sync_low_run <= 0;
         act_len      <= 0;
         lock_len     <= 0;
      end else begin
         low_run      <= !supply_low ? 0 :
                         (low_run < GLITCH_CYC) ? low_run + 1 : low_run;
         sync_low_run <= man_sync ? 0 :
                         (sync_low_run < DEBOUNCE_CYC) ? sync_low_run + 1 : sync_low_run;
         act_len      <= !rst_act ? 0 :
                         (act_len < TIMEOUT_CYC) ? act_len + 1 : act_len;
         lock_len     <= !lock_act ? 0 :
                         (lock_len <= LOCKOUT_CYC) ? lock_len + 1 : lock_len;
      end
   end

   // R2: supply flag accepted only after a full persistence run
   a_r2_dip_persist: assert property (@(posedge clk) disable iff (!rst_n)
      sup_flt |-> (low_run >= GLITCH_CYC));

   // R3: an accepted supply-low condition holds reset
   a_r3_hold_on_low: assert property (@(posedge clk) disable iff (!rst_n)
      sup_flt |=> rst_act);

   // R4: a debounced fall needs a full run of low synchronized samples
   a_r4_debounce_run: assert property (@(posedge clk) disable iff (!rst_n)
      man_fell |-> (sync_low_run >= DEBOUNCE_CYC));

   // R5: no reset interval is shorter than one time-out
   a_r5_min_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_act) |-> (act_len >= TIMEOUT_CYC));

   // R6: a reset not caused by the supply starts only from a debounced fall
   a_r6_start_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rst_act) && !$past(sup_flt)) |-> $past(man_fell));

   // R7: lock-out lasts exactly its window when not interrupted
   a_r7_lock_len: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(lock_act) && !$past(sup_flt)) |-> (lock_len == LOCKOUT_CYC));

   // R7: no manual reset starts from inside the lock-out
   a_r7_lock_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_act && !sup_flt) |=> !rst_act);

   // R8: a supply event cancels the lock-out and asserts reset
   a_r8_supply_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_act && sup_flt) |=> (rst_act && !lock_act));
endmodule

bind sup_reset_gen sup_reset_chk #(
   .TIMEOUT_CYC  (TIMEOUT_CYC),
   .LOCKOUT_CYC  (LOCKOUT_CYC),
   .GLITCH_CYC   (GLITCH_CYC),
   .DEBOUNCE_CYC (DEBOUNCE_CYC)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .supply_low (supply_low),
   .man_sync   (man_sync),
   .man_fell   (man_fell),
   .sup_flt    (sup_flt),
   .rst_act    (rst_act),
   .lock_act   (lock_act)
);

// File: tb/tb_sup_reset_gen.sv
`timescale 1ns/1ps
module tb_sup_reset_gen;
   localparam int T = 40;
   localparam int L = 12;
   localparam int G = 5;
   localparam int D = 3;
   localparam int S = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic supply_low = 1'b0;
   logic man_rst_n = 1'b1;
   logic dut_rst, hi_rst;
   int   cyc = 0;
   int   nchk = 0, nerr = 0;

   always #10 clk = ~clk;   // 50 MHz
   always @(posedge clk) cyc <= cyc + 1;

   sup_reset_gen #(.TIMEOUT_CYC(T), .LOCKOUT_CYC(L), .GLITCH_CYC(G),
                   .DEBOUNCE_CYC(D), .SYNC_STAGES(S), .ACTIVE_HIGH(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .supply_low(supply_low),
      .man_rst_n(man_rst_n), .sys_rst(dut_rst));

   sup_reset_gen #(.TIMEOUT_CYC(T), .LOCKOUT_CYC(L), .GLITCH_CYC(G),
                   .DEBOUNCE_CYC(D), .SYNC_STAGES(S), .ACTIVE_HIGH(1'b1)) dut_hi (
      .clk(clk), .rst_n(rst_n), .supply_low(supply_low),
      .man_rst_n(man_rst_n), .sys_rst(hi_rst));

   // ---------------- reference model built from the requirements ----------
   logic [S-1:0] m_sync;
   int  m_lvl, m_dcnt, m_fell, m_run, m_flt, m_st, m_cnt;
   // m_st: 0 hold, 1 recover, 2 idle, 3 manual, 4 lockout
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sync = '1; m_lvl = 1; m_dcnt = 0; m_fell = 0;
         m_run = 0; m_flt = 0; m_st = 0; m_cnt = 0;
      end else begin
         if (m_flt != 0) begin
            m_st = 0; m_cnt = 0;
         end else begin
            case (m_st)
               0: begin m_st = 1; m_cnt = 0; end
               1: begin m_cnt++; if (m_cnt == T) m_st = 2; end
               2: if (m_fell != 0) begin m_st = 3; m_cnt = 0; end
               3: begin m_cnt++; if (m_cnt == T) begin m_st = 4; m_cnt = 0; end end
               default: begin m_cnt++; if (m_cnt == L) m_st = 2; end
            endcase
         end
         m_run = supply_low ? m_run + 1 : 0;
         m_flt = (m_run >= G) ? 1 : 0;
         m_fell = 0;
         if (int'(m_sync[S-1]) != m_lvl) begin
            m_dcnt++;
            if (m_dcnt == D) begin
               m_lvl  = int'(m_sync[S-1]);
               m_dcnt = 0;
               m_fell = (m_lvl == 0) ? 1 : 0;
            end
         end else m_dcnt = 0;
         m_sync = {m_sync[S-2:0], man_rst_n};
      end
   end

   function automatic bit model_active(input int st);
      return (st == 0) || (st == 1) || (st == 3);
   endfunction

   // ---------------- checking helpers ----------------
   task automatic chk_act(input string tag, input bit exp_act);
      bit a;
      a = (dut_rst == 1'b0);
      nchk++;
      if (a !== exp_act) begin
         nerr++;
         $display("FAIL %s: reset active=%0d expected %0d (cycle %0d)", tag, a, exp_act, cyc);
      end
   endtask

   task automatic chk_hi(input string tag, input bit exp_lvl);
      nchk++;
      if (hi_rst !== exp_lvl) begin
         nerr++;
         $display("FAIL %s: active-high output=%0d expected %0d (cycle %0d)", tag, hi_rst, exp_lvl, cyc);
      end
   endtask

   task automatic to_edge(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nerr++; nchk++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      finish_run();
   end

   // ---------------- stimulus ----------------
   initial begin
      int c, c2, c3, p, r;
      int sup_left, man_left;
      void'($urandom(32'd20231));

      // R1: reset state and first time-out
      repeat (3) @(negedge clk);
      chk_act("R1 during block reset", 1'b1);
      chk_hi("R9 active-high during reset", 1'b1);
      rst_n = 1'b1;
      c = cyc;
      to_edge(c + T);     chk_act("R1 still held at edge T", 1'b1);
      to_edge(c + T + 1); chk_act("R1 released at edge T+1", 1'b0);
      chk_hi("R9 active-high released", 1'b0);

      // R2: short dip ignored
      c = cyc; supply_low = 1'b1;
      to_edge(c + G - 1); supply_low = 1'b0;
      to_edge(cyc + 10); chk_act("R2 short dip ignored", 1'b0);

      // R2/R3: accepted dip, hold and recovery
      c = cyc; supply_low = 1'b1;
      to_edge(c + G);     chk_act("R2 not yet accepted", 1'b0);
      to_edge(c + G + 1); chk_act("R2 accepted", 1'b1);
      to_edge(c + 100);   chk_act("R3 held while low", 1'b1);
      c2 = cyc; supply_low = 1'b0;
      to_edge(c2 + T + 1); chk_act("R3 held through time-out", 1'b1);
      to_edge(c2 + T + 2); chk_act("R3 released after time-out", 1'b0);

      // R4: manual glitch ignored
      c = cyc; man_rst_n = 1'b0;
      to_edge(c + D - 1); man_rst_n = 1'b1;
      to_edge(cyc + 20); chk_act("R4 manual glitch ignored", 1'b0);

      // R5: pulse start latency and fixed length while held low
      c = cyc; man_rst_n = 1'b0;
      to_edge(c + S + D);     chk_act("R5 before start", 1'b0);
      to_edge(c + S + D + 1); chk_act("R5 pulse started", 1'b1);
      p = c + S + D + 1;
      to_edge(p + T - 1); chk_act("R5 pulse last cycle", 1'b1);
      to_edge(p + T);     chk_act("R5 pulse ended despite low hold", 1'b0);
      to_edge(p + T + L + 30); chk_act("R7 held-low level no retrigger", 1'b0);

      // R6: falls during a pulse, R7: fall inside lock-out
      man_rst_n = 1'b1;
      to_edge(cyc + 10);
      c = cyc; man_rst_n = 1'b0;
      p = c + S + D + 1; r = p + T;
      to_edge(p + 4);  man_rst_n = 1'b1;
      to_edge(p + 14); man_rst_n = 1'b0;
      to_edge(p + 24); man_rst_n = 1'b1;
      to_edge(r - 2);  man_rst_n = 1'b0;
      to_edge(r - 1); chk_act("R6 pulse not extended", 1'b1);
      to_edge(r);     chk_act("R6 pulse ends on time", 1'b0);
      to_edge(r + L + 30); chk_act("R7 fall in lock-out ignored", 1'b0);
      man_rst_n = 1'b1;
      to_edge(cyc + 10);
      c = cyc; man_rst_n = 1'b0;
      to_edge(c + S + D + 1); chk_act("R7 rearmed after high-then-fall", 1'b1);
      r = c + S + D + 1 + T;

      // R8: supply during lock-out
      to_edge(r + 1); supply_low = 1'b1; man_rst_n = 1'b1;
      to_edge(r + 1 + G); chk_act("R8 in lock-out before accept", 1'b0);
      to_edge(r + 2 + G); chk_act("R8 supply overrides lock-out", 1'b1);
      to_edge(cyc + 20);
      c2 = cyc; supply_low = 1'b0;
      to_edge(c2 + T + 2); chk_act("R8 recovery after lock-out dip", 1'b0);
      c3 = cyc; man_rst_n = 1'b0;
      to_edge(c3 + S + D + 1); chk_act("R8 lock-out cancelled", 1'b1);

      // R8: supply during manual pulse
      p = c3 + S + D + 1;
      to_edge(p + 9); supply_low = 1'b1; man_rst_n = 1'b1;
      to_edge(p + 45); chk_act("R8 held past pulse end", 1'b1);
      to_edge(p + 60); supply_low = 1'b0;
      to_edge(p + 60 + T + 1); chk_act("R8 time-out restarted", 1'b1);
      to_edge(p + 60 + T + 2); chk_act("R8 released after restart", 1'b0);
      chk_hi("R9 active-high idle", 1'b0);

      // random phase judged against the reference model
      sup_left = 30; man_left = 20;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         chk_act("R2 R3 R5 R6 R7 R8 random vs model", model_active(m_st));
         chk_hi("R9 random polarity", model_active(m_st));
         if (sup_left == 0) begin
            supply_low = ~supply_low;
            if (supply_low) sup_left = ($urandom % 4 == 0) ? 40 + $urandom % 40 : 1 + $urandom % (G + 2);
            else            sup_left = 20 + $urandom % 150;
         end else sup_left--;
         if (man_left == 0) begin
            man_rst_n = ~man_rst_n;
            man_left = ($urandom % 3 == 0) ? 15 + $urandom % 70 : 1 + $urandom % (D + 2);
         end else man_left--;
      end
      finish_run();
   end
endmodule